// File: doc/BRIEF.md
# Random Access Scan Controller

This block wraps a bank of user state flip-flops so that, in test mode, each one can be written or read on its own, the way a cell of a RAM is reached, instead of being shifted through a serial chain. A test address is split into a row field and a column field. Each field drives its own decoder, and a flip-flop is selected only where its row line and its column line are both active. One scan-in bit is broadcast to the whole bank. Only the selected flip-flop takes it, and every other flip-flop keeps its value. A read steers the selected flip-flop onto a single observe output through a grid multiplexer and changes no state. A capture command loads every functional input at once, so the circuit's response can then be read back one bit at a time.

When test mode is low, every flip-flop loads its functional input on each clock. Commands are registered, then carried out by a small controller. Its states are ST_FUNC (functional loading), ST_HOLD (test mode, nothing happens), ST_WRITE, ST_READ and ST_CAPTURE. Transitions: from any state the controller goes to ST_FUNC when test mode is low. When test mode is high, it goes to ST_HOLD, ST_WRITE, ST_READ or ST_CAPTURE according to the command on the op input. A new command can be accepted on every cycle.

Top module: `rscan_bank`

## Requirements
- R1: While the controller is in ST_FUNC, every bit of `q` loads the matching bit of `func_d` on the next clock edge. With test mode low, the controller is in ST_FUNC from the cycle after the first edge that samples test mode low.
- R2: While `rst_n` is low, `q` is all zero, `read_valid` is 0 and `scan_out` is 0. The controller leaves reset in ST_FUNC.
- R3: A write command is sampled with test mode high and `op` = 01 at edge E. At edge E+1 only the addressed flip-flop loads the `scan_in` value sampled at E. Every other flip-flop holds.
- R4: The address is {row, column}. The row is in the upper `RB` bits and the column in the lower `CB` bits. The flip-flop index is row*COLS + column, where COLS = ceil(N/ROWS). At most one flip-flop is selected at any time.
- R5: A cycle with test mode high and `op` = 00 (idle) changes no flip-flop, whatever `func_d` does.
- R6: A read command is sampled with `op` = 10 at edge E. In the cycle after E, `read_valid` is 1 and `scan_out` equals the addressed flip-flop. A read changes no flip-flop.
- R7: An address that maps to no flip-flop writes nothing and reads 0. This covers a column ≥ COLS, a row ≥ ROWS, and an index ≥ N.
- R8: A capture command is sampled with `op` = 11 at edge E. At edge E+1 every flip-flop loads `func_d`.
- R9: Commands can be issued on back-to-back cycles. A read issued in the cycle right after a write or a capture returns the value that the write or capture produced.
- R10: The `op` input is ignored while test mode is low. A write command then has no effect, and `q` keeps following `func_d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Test mode select, broadcast to the bank |
| op | input | 2 | Command: 00 idle, 01 write, 10 read, 11 capture |
| addr | input | AW | Flip-flop address {row, column} |
| scan_in | input | 1 | Broadcast write data bit |
| func_d | input | N | Functional next-state inputs |
| q | output | N | Flip-flop outputs |
| scan_out | output | 1 | Observed bit of the addressed flip-flop |
| read_valid | output | 1 | High in the cycle that scan_out carries read data |

## Verification
Two operations can act on the same clock edge. In one case a write (or capture) takes effect on the same edge that moves the controller into a read of that same flip-flop. The bench provokes this by issuing a write or capture and then a read on the very next cycle, with no idle cycle between them. The read must return the new value: the scoreboard pushes the model value at issue time, and the monitor compares it when `read_valid` rises. In the other case test mode rises on the same edge that samples the first command, so the functional load and command acceptance coincide. That is judged by checking `q` against the functional pattern loaded on that edge.

// File: rtl/rscan_pkg.sv
package rscan_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_CAPTURE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_FUNC,
        ST_HOLD,
        ST_WRITE,
        ST_READ,
        ST_CAPTURE
    } state_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rscan_line_dec.sv
// One-hot line decoder: line k is active when the field equals k and k < LINES.
module rscan_line_dec #(
    parameter int LINES = 4,
    parameter int W     = 2
) (
    input  logic [W-1:0]     field,
    output logic [LINES-1:0] hot
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign hot[k] = (field == W'(k));
    end
endmodule

// File: rtl/rscan_cell.sv
// One bank flip-flop: functional load wins over scan load, else hold.
module rscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic func_load,
    input  logic scan_load,
    input  logic func_d,
    input  logic scan_d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (func_load)
            q <= func_d;
        else if (scan_load)
            q <= scan_d;
    end
endmodule

// File: rtl/rscan_fsm.sv
// Command controller: registers a command, then carries it out one cycle later.
module rscan_fsm
    import rscan_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic          scan_in,
    output state_e        state,
    output logic [AW-1:0] addr_q,
    output logic          din_q,
    output logic          load_all,
    output logic          write_en,
    output logic          read_en
);
    state_e state_d;

    always_comb begin
        state_d = ST_FUNC;
        if (test_mode) begin
            unique case (op_e'(op))
                OP_IDLE:    state_d = ST_HOLD;
                OP_WRITE:   state_d = ST_WRITE;
                OP_READ:    state_d = ST_READ;
                OP_CAPTURE: state_d = ST_CAPTURE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FUNC;
            addr_q <= '0;
            din_q  <= 1'b0;
        end else begin
            state <= state_d;
            if (test_mode && (op_e'(op) != OP_IDLE)) begin
                addr_q <= addr;
                din_q  <= scan_in;
            end
        end
    end

    always_comb begin
        load_all = 1'b0;
        write_en = 1'b0;
        read_en  = 1'b0;
        unique case (state)
            ST_FUNC:    load_all = 1'b1;
            ST_HOLD:    ;
            ST_WRITE:   write_en = 1'b1;
            ST_READ:    read_en  = 1'b1;
            ST_CAPTURE: load_all = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/rscan_bank.sv
module rscan_bank
    import rscan_pkg::*;
#(
    parameter  int N    = 18,
    parameter  int ROWS = 4,
    localparam int COLS = ceil_div(N, ROWS),
    localparam int RB   = idx_bits(ROWS),
    localparam int CB   = idx_bits(COLS),
    localparam int AW   = RB + CB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic          scan_in,
    input  logic [N-1:0]  func_d,
    output logic [N-1:0]  q,
    output logic          scan_out,
    output logic          read_valid
);
    state_e          state;
    logic [AW-1:0]   addr_q;
    logic            din_q;
    logic            load_all;
    logic            write_en;
    logic            read_en;
    logic [ROWS-1:0] row_hot;
    logic [COLS-1:0] col_hot;
    logic [N-1:0]    sel;

    rscan_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .op        (op),
        .addr      (addr),
        .scan_in   (scan_in),
        .state     (state),
        .addr_q    (addr_q),
        .din_q     (din_q),
        .load_all  (load_all),
        .write_en  (write_en),
        .read_en   (read_en)
    );

    rscan_line_dec #(.LINES(ROWS), .W(RB)) u_row_dec (
        .field (addr_q[AW-1:CB]),
        .hot   (row_hot)
    );

    rscan_line_dec #(.LINES(COLS), .W(CB)) u_col_dec (
        .field (addr_q[CB-1:0]),
        .hot   (col_hot)
    );

    // Grid: a flip-flop exists only where row*COLS+col < N.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            if (r * COLS + c < N) begin : g_ff
                assign sel[r*COLS+c] = row_hot[r] & col_hot[c];
                rscan_cell u_cell (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .func_load (load_all),
                    .scan_load (write_en & sel[r*COLS+c]),
                    .func_d    (func_d[r*COLS+c]),
                    .scan_d    (din_q),
                    .q         (q[r*COLS+c])
                );
            end
        end
    end

    assign scan_out   = read_en & (|(sel & q));
    assign read_valid = read_en;
endmodule

// File: rtl/rscan_bank_chk.sv
module rscan_bank_chk
    import rscan_pkg::*;
#(
    parameter int N = 18
) (
    input logic         clk,
    input logic         rst_n,
    input state_e       state,
    input logic [N-1:0] sel,
    input logic [N-1:0] q,
    input logic [N-1:0] func_d,
    input logic         din_q,
    input logic         scan_out,
    input logic         read_en
);
    AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FUNC) |=> (q == $past(func_d))); // R1
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R4
    AST_WRITE_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (((q ^ $past(q)) & ~$past(sel)) == '0)); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> ((q & $past(sel)) == ($past(din_q) ? $past(sel) : '0))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> $stable(q)); // R5
    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> $stable(q)); // R6
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && (sel == '0)) |-> !scan_out); // R7
    AST_UNMAPPED_WRITE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WRITE) && (sel == '0)) |=> $stable(q)); // R7
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |=> (q == $past(func_d))); // R8
endmodule

bind rscan_bank rscan_bank_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .sel      (sel),
    .q        (q),
    .func_d   (func_d),
    .din_q    (din_q),
    .scan_out (scan_out),
    .read_en  (read_en)
);

// File: tb/sim_rscan_bank.sv
`timescale 1ns/1ps
module sim_rscan_bank;
    localparam int N = 18, ROWS = 4, COLS = 5, RB = 2, CB = 3, AW = RB + CB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] addr = '0;
    logic          scan_in = 1'b0;
    logic [N-1:0]  func_d = '0;
    logic [N-1:0]  q;
    logic          scan_out;
    logic          read_valid;

    rscan_bank #(.N(N), .ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .op(op), .addr(addr),
        .scan_in(scan_in), .func_d(func_d), .q(q), .scan_out(scan_out),
        .read_valid(read_valid)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [N-1:0] model = '0;

    typedef struct {
        logic  val;
        string req;
        int    r;
        int    c;
    } exp_t;
    exp_t expq[$];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] a_rc(input int r, input int c);
        return {RB'(r), CB'(c)};
    endfunction

    function automatic bit mapped(input int r, input int c);
        return (r < ROWS) && (c < COLS) && (r * COLS + c < N);
    endfunction

    task automatic cmd(input logic [1:0] o, input logic [AW-1:0] a, input logic d);
        op = o; addr = a; scan_in = d;
        @(negedge clk);
        op = 2'b00;
    endtask

    task automatic do_write(input int r, input int c, input logic d);
        cmd(2'b01, a_rc(r, c), d);
        if (mapped(r, c)) model[r*COLS+c] = d;
    endtask

    task automatic do_read(input int r, input int c, input string req);
        exp_t e;
        e.val = mapped(r, c) ? model[r*COLS+c] : 1'b0;
        e.req = req; e.r = r; e.c = c;
        expq.push_back(e);
        cmd(2'b10, a_rc(r, c), 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare each read result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && read_valid) begin
            if (expq.size() == 0) begin
                check("R6", "unexpected read_valid", 32'(read_valid), 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(e.req, $sformatf("read r%0d c%0d", e.r, e.c),
                      32'(scan_out), 32'(e.val));
            end
        end
    end

    initial begin
        idle(3);
        // R2: reset state
        check("R2", "q in reset", 32'(q), 32'd0);
        check("R2", "read_valid in reset", 32'(read_valid), 32'd0);
        check("R2", "scan_out in reset", 32'(scan_out), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // R1: functional loading
        func_d = 18'h2A5C3; idle(1);
        check("R1", "func load A", 32'(q), 32'h2A5C3);
        func_d = 18'h15A3C; idle(1);
        check("R1", "func load B", 32'(q), 32'h15A3C);

        // R10: write command ignored while test mode low
        func_d = 18'h00F0F;
        cmd(2'b01, a_rc(0, 0), 1'b1);
        check("R10", "op ignored in functional mode", 32'(q), 32'h00F0F);

        // Enter test mode: the first edge still loads func_d
        func_d = 18'h0000F;
        test_mode = 1'b1; idle(1);
        model = 18'h0000F;
        check("R1", "load on test entry edge", 32'(q), 32'(model));
        // R5: idle test cycles hold whatever func_d does
        func_d = 18'h3FFF0; idle(3);
        check("R5", "hold during test idle", 32'(q), 32'(model));

        // R3 / R4: single writes
        do_write(1, 2, 1'b1); idle(1);
        check("R3", "write r1 c2", 32'(q), 32'(model));
        do_write(3, 2, 1'b1); idle(1);
        check("R4", "write last mapped r3 c2", 32'(q), 32'(model));
        do_write(0, 1, 1'b0); idle(1);
        check("R3", "write zero r0 c1", 32'(q), 32'(model));
        do_write(2, 4, 1'b1); idle(1);
        check("R4", "write r2 c4", 32'(q), 32'(model));

        // R7: unmapped writes
        do_write(1, 5, 1'b1); idle(1);
        check("R7", "write col beyond COLS", 32'(q), 32'(model));
        do_write(3, 3, 1'b1); idle(1);
        check("R7", "write index beyond N", 32'(q), 32'(model));
        do_write(0, 7, 1'b1); idle(1);
        check("R7", "write col 7", 32'(q), 32'(model));

        // R6: back-to-back reads of every mapped flip-flop
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (mapped(r, c)) do_read(r, c, "R6");
        idle(1);
        check("R6", "reads leave state", 32'(q), 32'(model));

        // R7: unmapped reads return 0
        do_read(3, 3, "R7");
        do_read(2, 6, "R7");
        idle(1);

        // R9: write then read the same flip-flop on the next cycle
        do_write(2, 0, 1'b1);
        do_read(2, 0, "R9");
        do_write(2, 0, 1'b0);
        do_read(2, 0, "R9");
        do_write(0, 4, 1'b1);
        do_write(1, 1, 1'b1);
        do_read(0, 4, "R9");
        do_read(1, 1, "R9");
        idle(1);
        check("R9", "state after pipelined ops", 32'(q), 32'(model));

        // R8: capture, then read back at once
        func_d = 18'h2C3A5;
        cmd(2'b11, a_rc(0, 0), 1'b0);
        model = 18'h2C3A5;
        do_read(0, 0, "R8");
        do_read(0, 2, "R8");
        do_read(3, 1, "R8");
        do_read(1, 3, "R8");
        func_d = 18'h00000;
        idle(1);
        check("R8", "capture loads all", 32'(q), 32'h2C3A5);

        // R1: leave test mode, functional loading resumes
        func_d = 18'h1234F;
        test_mode = 1'b0; idle(2);
        check("R1", "func load after exit", 32'(q), 32'h1234F);

        idle(2);
        check("R6", "all reads returned", 32'(expq.size()), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule